// File: doc/BRIEF.md
# Scanline Horizontal Sync and Blanking Generator

This block produces the horizontal timing of one video scanline at a time. Each line has a line type, and the type decides how the line is built. An image line has a sync pulse, a back porch, an active pixel region and a front porch. A dark line has a sync pulse and is blanked for the rest of the line. A progressive vertical-sync line has its sync inverted. An interlaced line is built from two half-lines, and each half is either an equalizing pulse or a broad pulse. The block drives the composite sync pin, a blanking flag, an active-pixel enable and a gated colour bus.

All segment lengths are counted in pixels. One pixel lasts a programmable number of system clocks. On the last clock of every line the block raises an end-of-line strobe for the vertical sequencer. On that same clock it samples the next line type and all timing inputs. Inputs that change at any other time have no effect on the line in progress.

Top module: `line_sync_gen`

## Requirements
- R1: Line type code 0 (image) produces, in this order: sync for `hsync_len` pixels, blank for `hback_len` pixels, active pixels for `hact_len` pixels, then blank for `hfront_len` pixels.
- R2: Line type code 1 (dark) asserts sync for `hsync_len` pixels, then blanks with sync released for `htot_len - hsync_len` pixels.
- R3: Line type code 2 (progressive vertical sync) asserts sync for `htot_len - hsync_len` pixels, then releases it for `hsync_len` pixels.
- R4: An interlaced line is made of two halves. The first half lasts `htot_len/2` pixels and the second half lasts `(htot_len+1)/2` pixels, rounded down. An equalizing half asserts sync for `hsync_len/2` pixels and is released for the rest of that half. A broad half asserts sync for (half length - `hsync_len`) pixels and is released for `hsync_len` pixels.
- R5: The half-line pair codes are: 3 = broad then broad, 4 = broad then equalizing, 5 = equalizing then equalizing, 6 = equalizing then broad. Code 7 behaves as a dark line.
- R6: Each pixel lasts `pix_div` system clocks. A value of 0 is treated as 1.
- R7: With `sync_neg` = 0, `csync_o` is high while sync is asserted. With `sync_neg` = 1, the pin is inverted.
- R8: `blank_o` is high in every segment except the active one. `pix_en_o` is high only in the active segment. `rgb_o` passes `rgb_in` while `pix_en_o` is high and is zero whenever `blank_o` is high.
- R9: `eol_o` is high for exactly one clock, on the last clock of each line. The next line starts with its first segment on the following clock.
- R10: The line type, all lengths, `pix_div` and `sync_neg` are sampled only on the clock where `eol_o` is high, and during reset. Changes to them at any other time do not alter the line in progress.
- R11: A synchronous active-high reset samples the inputs and holds the line at the first clock of its first segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_kind | input | 3 | Type of the next line (codes in R1, R2, R3 and R5) |
| hsync_len | input | 12 | Horizontal sync length in pixels |
| hback_len | input | 12 | Back porch length in pixels |
| hact_len | input | 12 | Active width in pixels |
| hfront_len | input | 12 | Front porch length in pixels |
| htot_len | input | 12 | Total line length in pixels (used by dark, vertical-sync and half-line types) |
| pix_div | input | 4 | System clocks per pixel |
| sync_neg | input | 1 | 1 selects negative sync polarity |
| rgb_in | input | COLOR_W | Pixel colour from the pixel source |
| csync_o | output | 1 | Composite sync pin |
| blank_o | output | 1 | Blanking flag |
| pix_en_o | output | 1 | Active-pixel enable |
| eol_o | output | 1 | End-of-line strobe |
| rgb_o | output | COLOR_W | Gated colour output |

## Verification
The end-of-line strobe and the sampling of the next line's configuration fall in the same clock. A wrong capture shows up either as a truncated line or as a line shaped by stale inputs. To provoke this, the bench sets an unrelated configuration early in each line and the intended one a cycle later, so the inputs always differ from the running line. The scoreboard then compares every clock of the next line, including its length and the position of its strobe, against a waveform built only from the intended configuration.

// File: rtl/lsg_pkg.sv
package lsg_pkg;

    localparam int LEN_W = 12;
    localparam int DIV_W = 4;
    localparam int NSEG  = 4;
    localparam int SEG_IDX_W = $clog2(NSEG);

    typedef enum logic [2:0] {
        LT_IMAGE = 3'd0,
        LT_DARK  = 3'd1,
        LT_VSYNC = 3'd2,
        LT_BB    = 3'd3,
        LT_BE    = 3'd4,
        LT_EE    = 3'd5,
        LT_EB    = 3'd6,
        LT_SPARE = 3'd7
    } line_kind_e;

    typedef enum logic [1:0] {
        SK_SYNC   = 2'd0,
        SK_BLANK  = 2'd1,
        SK_ACTIVE = 2'd2
    } seg_kind_e;

    typedef struct packed {
        logic [LEN_W-1:0] len;
        seg_kind_e        kind;
        logic             last;
    } seg_t;

    typedef struct packed {
        line_kind_e       kind;
        logic [LEN_W-1:0] hsync;
        logic [LEN_W-1:0] hback;
        logic [LEN_W-1:0] hact;
        logic [LEN_W-1:0] hfront;
        logic [LEN_W-1:0] htot;
        logic [DIV_W-1:0] cpp;
        logic             neg;
    } line_cfg_t;

    function automatic seg_t mk_seg(input logic [LEN_W-1:0] len,
                                    input seg_kind_e kind,
                                    input logic last);
        seg_t s;
        s.len  = len;
        s.kind = kind;
        s.last = last;
        return s;
    endfunction

    function automatic logic [DIV_W-1:0] fix_cpp(input logic [DIV_W-1:0] c);
        return (c == '0) ? DIV_W'(1) : c;
    endfunction

    function automatic logic half_is_broad(input line_kind_e k, input logic second);
        if (!second) return (k == LT_BB) || (k == LT_BE);
        else         return (k == LT_BB) || (k == LT_EB);
    endfunction

    function automatic logic is_half_pair(input line_kind_e k);
        return (k == LT_BB) || (k == LT_BE) || (k == LT_EE) || (k == LT_EB);
    endfunction

endpackage

// File: rtl/lsg_seg_plan.sv
module lsg_seg_plan
    import lsg_pkg::*;
(
    input  line_cfg_t             cfg,
    output seg_t [NSEG-1:0]       segs
);

    logic [LEN_W:0]          tot_p1;
    seg_t [NSEG-1:0]         pair_segs;

    assign tot_p1 = {1'b0, cfg.htot} + 1'b1;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [LEN_W-1:0] hlen;
        logic [LEN_W-1:0] slen;
        logic [LEN_W-1:0] rlen;
        logic             broad;

        assign hlen  = (h == 0) ? (cfg.htot >> 1) : tot_p1[LEN_W:1];
        assign broad = half_is_broad(cfg.kind, (h == 1));
        assign slen  = broad ? (hlen - cfg.hsync) : (cfg.hsync >> 1);
        assign rlen  = broad ? cfg.hsync : (hlen - (cfg.hsync >> 1));
        assign pair_segs[2*h]   = mk_seg(slen, SK_SYNC, 1'b0);
        assign pair_segs[2*h+1] = mk_seg(rlen, SK_BLANK, (h == 1));
    end

    always_comb begin
        seg_t fill;
        fill = mk_seg(cfg.htot - cfg.hsync, SK_BLANK, 1'b1);
        segs = {fill, fill, fill, mk_seg(cfg.hsync, SK_SYNC, 1'b0)};
        if (cfg.kind == LT_IMAGE) begin
            segs[0] = mk_seg(cfg.hsync,  SK_SYNC,   1'b0);
            segs[1] = mk_seg(cfg.hback,  SK_BLANK,  1'b0);
            segs[2] = mk_seg(cfg.hact,   SK_ACTIVE, 1'b0);
            segs[3] = mk_seg(cfg.hfront, SK_BLANK,  1'b1);
        end else if (cfg.kind == LT_VSYNC) begin
            segs[0] = mk_seg(cfg.htot - cfg.hsync, SK_SYNC,  1'b0);
            segs[1] = mk_seg(cfg.hsync,            SK_BLANK, 1'b1);
        end else if (is_half_pair(cfg.kind)) begin
            segs = pair_segs;
        end
    end

endmodule

// File: rtl/lsg_seg_seq.sv
module lsg_seg_seq
    import lsg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  seg_t [NSEG-1:0]       segs,
    input  logic [DIV_W-1:0]      cpp,
    output seg_kind_e             kind,
    output logic                  eol
);

    logic [DIV_W-1:0]     div_cnt;
    logic [SEG_IDX_W-1:0] idx;
    logic [LEN_W-1:0]     pos;
    seg_t                 cur;
    logic                 tick;
    logic                 seg_end;

    assign cur     = segs[idx];
    assign tick    = (div_cnt == cpp - 1'b1);
    assign seg_end = (pos == cur.len - 1'b1);
    assign eol     = tick && seg_end && cur.last;
    assign kind    = cur.kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            idx     <= '0;
            pos     <= '0;
        end else if (tick) begin
            div_cnt <= '0;
            if (seg_end) begin
                pos <= '0;
                idx <= cur.last ? '0 : idx + 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R6: divider never leaves its range
    p_div_range_r6: assert property (@(posedge clk) disable iff (rst)
        div_cnt < cpp);

    // R6: pixel position only advances on a pixel tick
    p_pos_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pos));

    // R9: strobe lasts a single clock
    p_eol_single_r9: assert property (@(posedge clk) disable iff (rst)
        eol |=> !eol);

    // R9: a new line opens at its first segment
    p_line_start_r9: assert property (@(posedge clk) disable iff (rst)
        eol |=> (idx == '0 && pos == '0 && div_cnt == '0));

endmodule

// File: rtl/line_sync_gen.sv
module line_sync_gen
    import lsg_pkg::*;
#(
    parameter int COLOR_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2:0]         line_kind,
    input  logic [LEN_W-1:0]   hsync_len,
    input  logic [LEN_W-1:0]   hback_len,
    input  logic [LEN_W-1:0]   hact_len,
    input  logic [LEN_W-1:0]   hfront_len,
    input  logic [LEN_W-1:0]   htot_len,
    input  logic [DIV_W-1:0]   pix_div,
    input  logic               sync_neg,
    input  logic [COLOR_W-1:0] rgb_in,
    output logic               csync_o,
    output logic               blank_o,
    output logic               pix_en_o,
    output logic               eol_o,
    output logic [COLOR_W-1:0] rgb_o
);

    line_cfg_t       cfg_in;
    line_cfg_t       cfg_q;
    seg_t [NSEG-1:0] segs;
    seg_kind_e       seg_kind;

    always_comb begin
        cfg_in.kind   = line_kind_e'(line_kind);
        cfg_in.hsync  = hsync_len;
        cfg_in.hback  = hback_len;
        cfg_in.hact   = hact_len;
        cfg_in.hfront = hfront_len;
        cfg_in.htot   = htot_len;
        cfg_in.cpp    = fix_cpp(pix_div);
        cfg_in.neg    = sync_neg;
    end

    always_ff @(posedge clk) begin
        if (rst || eol_o) cfg_q <= cfg_in;
    end

    lsg_seg_plan u_plan (
        .cfg  (cfg_q),
        .segs (segs)
    );

    lsg_seg_seq u_seq (
        .clk  (clk),
        .rst  (rst),
        .segs (segs),
        .cpp  (cfg_q.cpp),
        .kind (seg_kind),
        .eol  (eol_o)
    );

    assign csync_o  = (seg_kind == SK_SYNC) ^ cfg_q.neg;
    assign blank_o  = (seg_kind != SK_ACTIVE);
    assign pix_en_o = (seg_kind == SK_ACTIVE);
    assign rgb_o    = pix_en_o ? rgb_in : '0;

    // R10: configuration only moves at a line boundary
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(eol_o) && !$past(rst)) |-> $stable(cfg_q));

    // R8: colour is dark whenever blanking
    p_rgb_blank_r8: assert property (@(posedge clk) disable iff (rst)
        blank_o |-> (rgb_o == '0));

endmodule

// File: tb/line_sync_gen_tb.sv
module line_sync_gen_tb_top;
    import lsg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 12;
    localparam logic [CW-1:0] RGB_V = 12'hA5C;
    localparam int NLINES = 9;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [2:0]      line_kind;
    logic [LEN_W-1:0] hsync_len, hback_len, hact_len, hfront_len, htot_len;
    logic [DIV_W-1:0] pix_div;
    logic            sync_neg;
    logic [CW-1:0]   rgb_in = RGB_V;
    logic            csync_o, blank_o, pix_en_o, eol_o;
    logic [CW-1:0]   rgb_o;

    typedef struct { int kind; int hs; int bp; int act; int fp; int tot; int cpp; int neg; int ctx; } tcfg_t;
    typedef struct { logic cs; logic bl; logic pe; logic eo; logic [CW-1:0] rgb; int tag; int ctx; } item_t;

    item_t exp_q[$];
    tcfg_t lines[NLINES];
    tcfg_t junk;
    int    checks = 0;
    int    fails  = 0;
    bit    mon_on = 1'b0;
    bit    done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_sync_gen #(.COLOR_W(CW)) dut_i (
        .clk(clk), .rst(rst), .line_kind(line_kind),
        .hsync_len(hsync_len), .hback_len(hback_len), .hact_len(hact_len),
        .hfront_len(hfront_len), .htot_len(htot_len), .pix_div(pix_div),
        .sync_neg(sync_neg), .rgb_in(rgb_in), .csync_o(csync_o),
        .blank_o(blank_o), .pix_en_o(pix_en_o), .eol_o(eol_o), .rgb_o(rgb_o)
    );

    function automatic tcfg_t mk(int kind, int hs, int bp, int act, int fp,
                                 int tot, int cpp, int neg, int ctx);
        tcfg_t c;
        c.kind = kind; c.hs = hs; c.bp = bp; c.act = act; c.fp = fp;
        c.tot = tot; c.cpp = cpp; c.neg = neg; c.ctx = ctx;
        return c;
    endfunction

    task automatic apply(input tcfg_t c);
        line_kind  = 3'(c.kind);
        hsync_len  = LEN_W'(c.hs);
        hback_len  = LEN_W'(c.bp);
        hact_len   = LEN_W'(c.act);
        hfront_len = LEN_W'(c.fp);
        htot_len   = LEN_W'(c.tot);
        pix_div    = DIV_W'(c.cpp);
        sync_neg   = c.neg[0];
    endtask

    task automatic chk(input logic act, input logic exp, input int tag,
                       input int ctx, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d (context R%0d) %s: actual=%0b expected=%0b at %0t",
                     tag, ctx, what, act, exp, $time);
        end
    endtask

    // Driver: builds the expected waveform of a line from the requirements
    task automatic push_line(input tcfg_t c);
        int sl[4];
        int sk[4];     // 0 sync, 1 blank, 2 active
        int n;
        int tag;
        int cp;
        int total;
        int k;
        item_t it;
        cp = (c.cpp == 0) ? 1 : c.cpp;              // R6
        n = 2;
        sl = '{0, 0, 0, 0};
        sk = '{0, 1, 0, 1};
        if (c.kind == 0) begin                       // R1
            n = 4; tag = 1;
            sl = '{c.hs, c.bp, c.act, c.fp};
            sk = '{0, 1, 2, 1};
        end else if (c.kind == 2) begin              // R3
            tag = 3;
            sl[0] = c.tot - c.hs; sl[1] = c.hs;
        end else if (c.kind >= 3 && c.kind <= 6) begin   // R4, R5
            n = 4; tag = 5;
            for (int h = 0; h < 2; h++) begin
                int hl;
                bit broad;
                hl = (h == 0) ? c.tot / 2 : (c.tot + 1) / 2;
                broad = (h == 0) ? (c.kind == 3 || c.kind == 4)
                                 : (c.kind == 3 || c.kind == 6);
                sl[2*h]   = broad ? hl - c.hs : c.hs / 2;
                sl[2*h+1] = broad ? c.hs : hl - c.hs / 2;
            end
        end else begin                               // R2
            tag = 2;
            sl[0] = c.hs; sl[1] = c.tot - c.hs;
        end
        total = 0;
        for (int s = 0; s < n; s++) total += sl[s] * cp;
        k = 0;
        for (int s = 0; s < n; s++) begin
            for (int p = 0; p < sl[s] * cp; p++) begin
                k++;
                it.cs  = (sk[s] == 0) ^ c.neg[0];    // R7
                it.bl  = (sk[s] != 2);               // R8
                it.pe  = (sk[s] == 2);
                it.rgb = (sk[s] == 2) ? RGB_V : '0;
                it.eo  = (k == total);               // R9
                it.tag = (c.neg != 0) ? 7 : tag;
                it.ctx = c.ctx;
                exp_q.push_back(it);
            end
        end
    endtask

    // Monitor: pops one expected item per clock, sampled at the falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (exp_q.size() == 0) begin
                mon_on = 1'b0;
                done   = 1'b1;
            end else begin
                item_t it;
                it = exp_q.pop_front();
                chk(csync_o,  it.cs, it.tag, it.ctx, "csync");
                chk(blank_o,  it.bl, 8, it.ctx, "blank");
                chk(pix_en_o, it.pe, 8, it.ctx, "pix_en");
                chk(eol_o,    it.eo, 9, it.ctx, "eol");
                checks++;
                if (rgb_o !== it.rgb) begin
                    fails++;
                    $display("FAIL R8 (context R%0d) rgb: actual=%h expected=%h at %0t",
                             it.ctx, rgb_o, it.rgb, $time);
                end
            end
        end
    end

    initial begin
        lines[0] = mk(0, 4, 3, 8, 2, 17, 2, 0, 6);   // R1 image, R6 two clocks per pixel
        lines[1] = mk(1, 4, 0, 0, 0, 17, 1, 0, 10);  // R2 dark, R10 after input churn
        lines[2] = mk(2, 4, 0, 0, 0, 17, 3, 0, 6);   // R3 vertical sync, R6 three clocks
        lines[3] = mk(3, 4, 0, 0, 0, 21, 1, 0, 4);   // R5 broad+broad, odd total R4
        lines[4] = mk(4, 4, 0, 0, 0, 21, 2, 0, 4);   // R5 broad+equalizing
        lines[5] = mk(5, 6, 0, 0, 0, 20, 1, 0, 4);   // R5 equalizing pair
        lines[6] = mk(6, 5, 0, 0, 0, 21, 1, 1, 7);   // R5 equalizing+broad, R7 negative
        lines[7] = mk(0, 2, 1, 5, 1, 17, 1, 1, 7);   // R7 negative image line
        lines[8] = mk(0, 2, 2, 3, 2, 17, 0, 0, 6);   // R6 divider value 0 acts as 1
        junk     = mk(5, 8, 9, 9, 9, 40, 4, 1, 10);

        apply(lines[0]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset holds the first clock of the first segment of line 0
        chk(csync_o,  1'b1, 11, 11, "reset csync");
        chk(blank_o,  1'b1, 11, 11, "reset blank");
        chk(pix_en_o, 1'b0, 11, 11, "reset pix_en");
        chk(eol_o,    1'b0, 11, 11, "reset eol");
        for (int i = 0; i < NLINES; i++) push_line(lines[i]);

        @(posedge clk);
        #1;
        rst    = 1'b0;
        mon_on = 1'b1;
        for (int i = 0; i < NLINES; i++) begin
            // R10: unrelated inputs mid-line must not disturb the running line
            apply(junk);
            @(negedge clk);
            apply((i + 1 < NLINES) ? lines[i+1] : lines[i]);
            do @(negedge clk); while (eol_o !== 1'b1);
            @(posedge clk);
            #1;
        end
        while (!done) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule